// File: doc/BRIEF.md
# Interval Timer Register Access Controller

This block is the host-facing register front end of a small bank of 16-bit interval counters. A host reaches it through an 8-bit bus with a 2-bit address and separate read and write strobes. Addresses 0 to 2 reach the data ports of channels 0 to 2. Address 3 is the command port. Command bytes either program a channel's byte-access pattern or freeze a channel's count for a clean two-byte read. Data bytes are steered into or out of the addressed channel, one byte per bus access.

Each channel keeps its own read pointer and write pointer, which say whether the next byte is the low or the high half. It also keeps an output latch that holds a snapshot of the count, with one pending flag for each half. Each channel has a down-counter that drops by one on every cycle its tick input is high, so the host always has a moving value to read or freeze. A read-back command can freeze several channels at once.

Top module: `ptimer_regif`

## Requirements
- R1: A write to address 3 is a command byte: bits 7:6 pick the channel (3 means read-back) and bits 5:4 pick the access pattern. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. A read from address 3 returns 0x00 and leaves every channel's read sequence unchanged.
- R2: An access value of 1 (low byte only), 2 (high byte only) or 3 (low then high) programs the channel. Both pointers move to the first byte of that pattern, and latched bytes not yet read are discarded, so the next read returns live data. The count itself is kept.
- R3: A data write in low-only access loads the counter with {0x00, byte}. In high-only access it loads {byte, 0x00}. In low-then-high access the first byte is held as the low half and the second byte loads {second, first} into the counter.
- R4: The counter decrements by one on every cycle its tick input is high and wraps from 0x0000 to 0xFFFF. A load in the same cycle wins over the tick.
- R5: With nothing latched, a data read returns the live low or high byte as the read pointer selects. In low-then-high access the pointer alternates after each read. In a single-byte access it stays put.
- R6: An access value of 0 is a latch command. It copies the count into the output latch and marks the low byte pending (low-only), the high byte pending (high-only) or both (low-then-high). The channel's access pattern is unchanged.
- R7: Pending latched bytes are returned low first, then high, each clearing as it is read. Later reads return live data.
- R8: A latch command is ignored while either latched byte of that channel is still pending.
- R9: A latch taken in low-then-high access after a live low byte was read, but before its high byte, resets the read pointer to low and marks both halves pending.
- R10: A read-back command (channel field 3) with bit 5 low latches every channel i whose bit i+1 is set, under the same rules as R6 to R8. With bit 5 high it latches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 to 2 channel data, 3 command |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_rdata | output | DATA_W (8) | Read data, combinational from the address and the state |
| ch_tick | input | NUM_CH (3) | Per-channel decrement enable |

## Verification
The bench builds the block with its defaults: three channels and 8-bit data, which makes 16-bit counts. This brings the read-back selection bits for every channel into play, including an unselected channel that must keep its pointer. The 16-bit counter width lets the bench drive the wrap from 0x0000 to 0xFFFF with two ticks and check that the frozen and live values visibly differ. The count and all three access patterns are observable through byte reads alone.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_WORD  = 2'd3
   } acc_e;

   localparam logic [1:0] CMD_ADDR = 2'd3;
   localparam logic [1:0] SEL_READBACK = 2'd3;
endpackage

// File: rtl/ptimer_cmd_dec.sv
module ptimer_cmd_dec
   import ptimer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   output logic [NUM_CH-1:0] prog,
   output acc_e              prog_acc,
   output logic [NUM_CH-1:0] latch,
   output logic [NUM_CH-1:0] dwr
);
   logic       cmd_wr;
   logic [1:0] sel;
   acc_e       acc;

   assign cmd_wr   = bus_wr && (bus_addr == CMD_ADDR);
   assign sel      = bus_wdata[7:6];
   assign acc      = acc_e'(bus_wdata[5:4]);
   assign prog_acc = acc;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      logic rb_pick;
      assign hit     = (sel == 2'(i));
      assign rb_pick = (sel == SEL_READBACK) && !bus_wdata[5] && bus_wdata[i+1];
      assign prog[i]  = cmd_wr && hit && (acc != ACC_LATCH);
      assign latch[i] = cmd_wr && ((hit && (acc == ACC_LATCH)) || rb_pick);
      assign dwr[i]   = bus_wr && (bus_addr == 2'(i));

      AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(prog[i] && latch[i]));  // R1
   end

   AST_PROG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog));  // R1
   AST_DATA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dwr));  // R1
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
   import ptimer_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  acc_e              prog_acc,
   input  logic              latch,
   input  logic              dwr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic              tick,
   output logic [DATA_W-1:0] rd_byte
);
   acc_e              acc_q;
   logic              rd_hi_q, wr_hi_q;
   logic              lo_pend, hi_pend;
   logic [CNT_W-1:0]  olatch_q, count_q;
   logic [DATA_W-1:0] in_lo_q;
   logic              null_q;
   logic              load, take_latch, word;
   logic [CNT_W-1:0]  load_val;

   assign word       = (acc_q == ACC_WORD);
   assign load       = dwr && (!word || wr_hi_q);
   assign take_latch = latch && !lo_pend && !hi_pend;

   always_comb begin
      unique case (acc_q)
         ACC_HI:  load_val = {wdata, {DATA_W{1'b0}}};
         ACC_WORD: load_val = {wdata, in_lo_q};
         default: load_val = {{DATA_W{1'b0}}, wdata};
      endcase
   end

   always_comb begin
      if (lo_pend)      rd_byte = olatch_q[DATA_W-1:0];
      else if (hi_pend) rd_byte = olatch_q[CNT_W-1:DATA_W];
      else if (rd_hi_q) rd_byte = count_q[CNT_W-1:DATA_W];
      else              rd_byte = count_q[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= ACC_LO;
         rd_hi_q  <= 1'b0;
         wr_hi_q  <= 1'b0;
         lo_pend  <= 1'b0;
         hi_pend  <= 1'b0;
         olatch_q <= '0;
         in_lo_q  <= '0;
         null_q   <= 1'b0;
      end else begin
         if (prog) begin
            acc_q   <= prog_acc;
            rd_hi_q <= (prog_acc == ACC_HI);
            wr_hi_q <= (prog_acc == ACC_HI);
            lo_pend <= 1'b0;
            hi_pend <= 1'b0;
            null_q  <= 1'b1;
         end else begin
            if (take_latch) begin
               olatch_q <= count_q;
               lo_pend  <= (acc_q != ACC_HI);
               hi_pend  <= (acc_q != ACC_LO);
               if (word) rd_hi_q <= 1'b0;
            end else if (rd) begin
               if (lo_pend)      lo_pend <= 1'b0;
               else if (hi_pend) hi_pend <= 1'b0;
               if (word) rd_hi_q <= !rd_hi_q;
            end
            if (dwr && word && !wr_hi_q) begin
               in_lo_q <= wdata;
               wr_hi_q <= 1'b1;
            end else if (load) begin
               if (word) wr_hi_q <= 1'b0;
               null_q <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    count_q <= '0;
      else if (load) count_q <= load_val;
      else if (tick) count_q <= count_q - 1'b1;
   end

   AST_PROG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      prog |=> !lo_pend && !hi_pend);  // R2
   AST_LOAD_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !null_q);  // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !load |=> $stable(count_q));  // R4
   AST_SINGLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q == ACC_LO |-> !rd_hi_q && !wr_hi_q);  // R5
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_pend || hi_pend) && !prog |=> $stable(olatch_q));  // R8
endmodule

// File: rtl/ptimer_regif.sv
module ptimer_regif
   import ptimer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_tick
);
   if (DATA_W < 8) begin : g_bad_width
      $error("ptimer_regif: DATA_W must hold an 8-bit command byte");
   end
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_count
      $error("ptimer_regif: NUM_CH must be 1 to 3");
   end

   logic [NUM_CH-1:0] prog, latch, dwr;
   acc_e              prog_acc;
   logic [DATA_W-1:0] ch_byte [NUM_CH];

   ptimer_cmd_dec #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_wr   (bus_wr),
      .prog     (prog),
      .prog_acc (prog_acc),
      .latch    (latch),
      .dwr      (dwr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ptimer_chan #(.DATA_W(DATA_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .prog    (prog[i]),
         .prog_acc(prog_acc),
         .latch   (latch[i]),
         .dwr     (dwr[i]),
         .wdata   (bus_wdata),
         .rd      (bus_rd && (bus_addr == 2'(i))),
         .tick    (ch_tick[i]),
         .rd_byte (ch_byte[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (bus_addr == 2'(i)) bus_rdata = ch_byte[i];
   end

   AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (bus_addr == CMD_ADDR) |-> bus_rdata == '0);  // R1
endmodule

// File: tb/sim_ptimer_regif.sv
module sim_ptimer_regif;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [2:0] ch_tick = '0;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = !clk;

   ptimer_regif u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_tick(ch_tick)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(req, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [2:0] mask, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ch_tick = mask;
      end
      @(negedge clk);
      ch_tick = '0;
   endtask

   task automatic t_reset();
      rd_chk(2'd0, 8'h00, "R1 reset ch0");
      rd_chk(2'd1, 8'h00, "R1 reset ch1");
      rd_chk(2'd3, 8'h00, "R1 command read");
   endtask

   task automatic t_word();
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h34);
      wr(2'd0, 8'h12);
      rd_chk(2'd0, 8'h34, "R3 word low");
      rd_chk(2'd0, 8'h12, "R3 word high");
      rd_chk(2'd0, 8'h34, "R5 pointer alternates");
      rd_chk(2'd0, 8'h12, "R5 pointer alternates");
      pulse(3'b001, 5);
      rd_chk(2'd0, 8'h2F, "R4 decrement low");
      rd_chk(2'd0, 8'h12, "R4 decrement high");
   endtask

   task automatic t_single();
      wr(2'd3, 8'h50);
      wr(2'd1, 8'hAB);
      rd_chk(2'd1, 8'hAB, "R3 low-only load");
      rd_chk(2'd1, 8'hAB, "R5 single pointer fixed");
      wr(2'd3, 8'h60);
      wr(2'd1, 8'hCD);
      rd_chk(2'd1, 8'hCD, "R3 high-only load");
   endtask

   task automatic t_wrap_priority();
      wr(2'd3, 8'h90);
      wr(2'd2, 8'h01);
      pulse(3'b100, 2);
      rd_chk(2'd2, 8'hFF, "R4 wrap");
      wr(2'd3, 8'hB0);
      rd_chk(2'd2, 8'hFF, "R2 reprogram keeps count low");
      rd_chk(2'd2, 8'hFF, "R2 reprogram keeps count high");
      wr(2'd2, 8'h10);
      @(negedge clk);
      bus_addr = 2'd2; bus_wdata = 8'h20; bus_wr = 1'b1; ch_tick = 3'b100;
      @(negedge clk);
      bus_wr = 1'b0; ch_tick = '0;
      rd_chk(2'd2, 8'h10, "R4 load beats tick low");
      rd_chk(2'd2, 8'h20, "R4 load beats tick high");
   endtask

   task automatic t_latch();
      wr(2'd3, 8'h00);
      pulse(3'b001, 3);
      rd_chk(2'd0, 8'h2F, "R7 latched low");
      rd_chk(2'd0, 8'h12, "R7 latched high");
      rd_chk(2'd0, 8'h2C, "R6 live after latch, word pattern kept");
      rd_chk(2'd0, 8'h12, "R6 live high");
   endtask

   task automatic t_ignore();
      wr(2'd3, 8'h00);
      pulse(3'b001, 4);
      wr(2'd3, 8'h00);
      rd_chk(2'd0, 8'h2C, "R8 second latch ignored");
      pulse(3'b001, 1);
      wr(2'd3, 8'h00);
      rd_chk(2'd0, 8'h12, "R8 ignored with high pending");
      wr(2'd3, 8'h00);
      pulse(3'b001, 1);
      rd_chk(2'd0, 8'h27, "R8 fresh latch low");
      rd_chk(2'd0, 8'h12, "R8 fresh latch high");
   endtask

   task automatic t_midread();
      rd_chk(2'd0, 8'h26, "R9 live low before latch");
      pulse(3'b001, 16);
      wr(2'd3, 8'h00);
      rd_chk(2'd0, 8'h16, "R9 latched low");
      rd_chk(2'd0, 8'h12, "R9 latched high");
      rd_chk(2'd0, 8'h16, "R9 pointer back at low");
   endtask

   task automatic t_lo_latch_discard();
      wr(2'd3, 8'h50);
      wr(2'd1, 8'h77);
      wr(2'd3, 8'h40);
      pulse(3'b010, 5);
      rd_chk(2'd1, 8'h77, "R6 low-only latch");
      rd_chk(2'd1, 8'h72, "R6 high not pending in low-only");
      wr(2'd3, 8'h40);
      wr(2'd3, 8'h50);
      pulse(3'b010, 2);
      rd_chk(2'd1, 8'h70, "R2 program discards latch");
   endtask

   task automatic t_readback();
      wr(2'd3, 8'hDC);
      pulse(3'b110, 3);
      rd_chk(2'd0, 8'h12, "R10 unselected ch0 live");
      rd_chk(2'd1, 8'h70, "R10 ch1 latched");
      rd_chk(2'd2, 8'h10, "R10 ch2 latched low");
      rd_chk(2'd2, 8'h20, "R10 ch2 latched high");
      rd_chk(2'd1, 8'h6D, "R10 ch1 live after");
      wr(2'd3, 8'hFC);
      pulse(3'b100, 1);
      rd_chk(2'd2, 8'h0C, "R10 bit5 high latches nothing");
      rd_chk(2'd3, 8'h00, "R1 command read no effect");
      rd_chk(2'd0, 8'h16, "R1 ch0 sequence unchanged");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word();
      t_single();
      t_wrap_priority();
      t_latch();
      t_ignore();
      t_midread();
      t_lo_latch_discard();
      t_readback();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule